// File: doc/BRIEF.md
# One-Wire Search Step Sequencer

This block carries out a single branch decision of the one-wire device enumeration walk without software stepping through each time slot. Once it is started, it asks the underlying single-bit slot engine for two read slots, the true bit and then the inverted bit of the current address position. From that pair it settles which branch to follow, sends the chosen branch as one write slot, and then reports a three-bit outcome code.

Software provides a preferred branch with each start. That preference is used only when both values appear on the line, meaning the devices present disagree at this position. Software keeps track of discrepancy positions over the whole address and checks the CRC. Each slot the block issues is watched by a timeout counter. If a slot engine fails to report completion in time, the step is abandoned and the block returns the code for "nobody answered".

Top module: `owsrch_step`

## Requirements
- R1: A step issues up to three slots, strictly in this order: a read (`slot_write_o`=0), a second read (`slot_write_o`=0), then a write (`slot_write_o`=1). Each slot request is a `slot_start_o` pulse one cycle long, and the next request waits until the previous slot has completed.
- R2: When both read values are 1, the step finishes with `result_o`=3'b011 and issues no write slot.
- R3: When both read values are 0, the block writes the preferred branch sampled at start. The result is 3'b100 for a preference of 1 and 3'b000 for a preference of 0.
- R4: When exactly one read value is 1, the block writes the first read value regardless of the preference. The result is 3'b101 when the first value is 1 and 3'b010 when it is 0.
- R5: If a slot is still not complete after TIMEOUT_CYC cycles of waiting, the step ends at once with `result_o`=3'b011 and issues no further slot. A completion that arrives in the final allowed cycle is accepted.
- R6: `result_o` bit 0 holds the first read value, bit 1 the second read value, and bit 2 the branch taken. `done_o` is a single-cycle pulse. `result_o` changes only while `done_o` is high and otherwise holds its value.
- R7: A `go_i` received while `busy_o` is high is ignored. It adds no slot and does not queue a later step.
- R8: The preference is captured in the cycle `go_i` is accepted. Changes to `pref_dir_i` during the step have no effect.
- R9: After reset, `busy_o`, `done_o` and `slot_start_o` are low and `result_o` is 3'b000. `busy_o` is high from the cycle after an accepted `go_i` until the cycle in which `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start pulse for one search step |
| pref_dir_i | input | 1 | Preferred branch used when devices disagree |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {branch, second read, first read} |
| slot_start_o | output | 1 | Slot request pulse to the bit engine |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wval_o | output | 1 | Bit value for a write slot |
| slot_done_i | input | 1 | Slot completion pulse from the bit engine |
| slot_rval_i | input | 1 | Sampled line value, valid with slot_done_i |

## Verification
The hardest case to reach is the timeout boundary. Completion must arrive in exactly the last allowed waiting cycle, or one cycle after it, and this has to be shown separately for each of the three slots. The bench models the bit engine with a programmable response latency and a selectable silent slot. It sets the timeout to a small value, runs latencies up to and past the limit, and silences each slot position in turn. All eight combinations of the two read values and the preference are swept at several latencies.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISS_ID,
        ST_WAIT_ID,
        ST_ISS_CMP,
        ST_WAIT_CMP,
        ST_ISS_WR,
        ST_WAIT_WR
    } step_state_e;

    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } step_code_t;

    localparam step_code_t CODE_NONE = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};

    // branch choice: a single answering polarity forces it, else preference
    function automatic logic pick_dir(input logic id, input logic cmp, input logic pref);
        return (id ^ cmp) ? id : pref;
    endfunction

    function automatic logic code_legal(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b100) || (c == 3'b101) ||
               (c == 3'b010) || (c == 3'b011);
    endfunction

endpackage

// File: rtl/owsrch_wait_timer.sv
module owsrch_wait_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    // counts waiting cycles; cleared whenever no slot is outstanding
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/owsrch_pick.sv
module owsrch_pick
    import owsrch_pkg::*;
(
    input  logic       id_bit,
    input  logic       cmp_bit,
    input  logic       pref,
    output logic       dir,
    output logic       nobody,
    output step_code_t code
);
    always_comb begin
        dir    = pick_dir(id_bit, cmp_bit, pref);
        nobody = id_bit & cmp_bit;
        code   = nobody ? CODE_NONE : '{dir: dir, cmp: cmp_bit, id: id_bit};
    end
endmodule

// File: rtl/owsrch_step.sv
module owsrch_step
    import owsrch_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       pref_dir_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] result_o,
    output logic       slot_start_o,
    output logic       slot_write_o,
    output logic       slot_wval_o,
    input  logic       slot_done_i,
    input  logic       slot_rval_i
);
    step_state_e state_q, state_d;
    logic        id_q, cmp_q, pref_q;
    logic        done_q;
    step_code_t  res_q;
    logic        tmr_run, tmr_exp;
    logic        finish;
    step_code_t  fin_code;
    logic        pk_dir, pk_nobody;
    step_code_t  pk_code;

    owsrch_wait_timer #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    owsrch_pick pick_i (
        .id_bit  (id_q),
        .cmp_bit (cmp_q),
        .pref    (pref_q),
        .dir     (pk_dir),
        .nobody  (pk_nobody),
        .code    (pk_code)
    );

    always_comb begin
        state_d      = state_q;
        slot_start_o = 1'b0;
        slot_write_o = 1'b0;
        tmr_run      = 1'b0;
        finish       = 1'b0;
        fin_code     = CODE_NONE;
        unique case (state_q)
            ST_IDLE: if (go_i) state_d = ST_ISS_ID;
            ST_ISS_ID: begin
                slot_start_o = 1'b1;
                state_d      = ST_WAIT_ID;
            end
            ST_WAIT_ID: begin
                tmr_run = 1'b1;
                if (slot_done_i) begin
                    state_d = ST_ISS_CMP;
                end else if (tmr_exp) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_ISS_CMP: begin
                slot_start_o = 1'b1;
                state_d      = ST_WAIT_CMP;
            end
            ST_WAIT_CMP: begin
                tmr_run = 1'b1;
                if (slot_done_i) begin
                    if (id_q && slot_rval_i) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_ISS_WR;
                    end
                end else if (tmr_exp) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_ISS_WR: begin
                slot_start_o = 1'b1;
                slot_write_o = 1'b1;
                state_d      = ST_WAIT_WR;
            end
            ST_WAIT_WR: begin
                tmr_run = 1'b1;
                if (slot_done_i) begin
                    state_d  = ST_IDLE;
                    finish   = 1'b1;
                    fin_code = pk_code;
                end else if (tmr_exp) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            id_q    <= 1'b0;
            cmp_q   <= 1'b0;
            pref_q  <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (finish) res_q <= fin_code;
            if (state_q == ST_IDLE && go_i) pref_q <= pref_dir_i;
            if (state_q == ST_WAIT_ID && slot_done_i) id_q <= slot_rval_i;
            if (state_q == ST_WAIT_CMP && slot_done_i) cmp_q <= slot_rval_i;
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign result_o    = res_q;
    assign slot_wval_o = pk_dir;

    p_slot_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        slot_start_o |=> !slot_start_o);
    p_no_write_none_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_start_o && slot_write_o) |-> !(id_q && cmp_q));
    p_forced_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_start_o && slot_write_o && (id_q != cmp_q)) |-> (slot_wval_o == id_q));
    p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> code_legal(result_o));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && go_i && !finish) |=> busy_o);

endmodule

// File: tb/owsrch_step_tb_top.sv
module owsrch_step_tb_top;
    localparam int T = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       busy_o, done_o;
    logic [2:0] result_o;
    logic       slot_start_o, slot_write_o, slot_wval_o;
    logic       slot_done_i = 1'b0;
    logic       slot_rval_i = 1'b0;

    always #4 clk = ~clk;

    owsrch_step #(.TIMEOUT_CYC(T)) dut_i (
        .clk(clk), .rst(rst), .go_i(go_i), .pref_dir_i(pref_dir_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .slot_start_o(slot_start_o), .slot_write_o(slot_write_o),
        .slot_wval_o(slot_wval_o), .slot_done_i(slot_done_i),
        .slot_rval_i(slot_rval_i)
    );

    int checks = 0;
    int fails  = 0;

    // bit engine model configuration and log
    logic       rsp_bit [2];
    int         rsp_delay = 1;
    int         silent_idx = 3;
    int         slot_cnt = 0;
    logic [2:0] wr_flags = '0;
    logic       last_wval = 1'b0;
    bit         pending = 0;
    int         cd = 0;
    int         cur_idx = 0;

    always @(negedge clk) begin
        slot_done_i = 1'b0;
        if (pending) begin
            cd = cd - 1;
            if (cd == 0) begin
                slot_done_i = 1'b1;
                slot_rval_i = (cur_idx < 2) ? rsp_bit[cur_idx] : 1'b0;
                pending = 0;
            end
        end
        if (slot_start_o) begin
            cur_idx = slot_cnt;
            if (slot_cnt < 3) wr_flags[slot_cnt] = slot_write_o;
            if (slot_write_o) last_wval = slot_wval_o;
            slot_cnt = slot_cnt + 1;
            pending = (cur_idx != silent_idx);
            cd = rsp_delay;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic pref);
        @(negedge clk);
        go_i = 1'b1;
        pref_dir_i = pref;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
    endtask

    // one full step with expectations computed from the requirement rules
    task automatic run_step(input logic id, input logic cmp, input logic pref,
                            input int dly, input int silent, input string tag);
        logic [2:0] exp_res;
        int exp_slots;
        logic dir;
        logic [2:0] held;
        rsp_bit[0] = id; rsp_bit[1] = cmp;
        rsp_delay = dly; silent_idx = silent;
        slot_cnt = 0; wr_flags = '0;
        pulse_go(pref);
        chk({tag, " busy"}, busy_o, 1'b1);
        wait_done();
        if (silent < 3 && !(silent == 2 && id && cmp)) begin
            exp_res = 3'b011; exp_slots = silent + 1;
        end else if (dly > T) begin
            exp_res = 3'b011; exp_slots = 1;
        end else if (id && cmp) begin
            exp_res = 3'b011; exp_slots = 2;
        end else begin
            dir = (id != cmp) ? id : pref;
            exp_res = {dir, cmp, id}; exp_slots = 3;
            chk({tag, " R1 write flags"}, wr_flags, 3'b100);
            chk({tag, " wval"}, last_wval, dir);
        end
        chk({tag, " done"}, done_o, 1'b1);
        chk({tag, " result"}, result_o, exp_res);
        chk({tag, " slots"}, slot_cnt, exp_slots);
        held = result_o;
        @(negedge clk);
        chk("R6 done one cycle", done_o, 1'b0);
        chk("R9 busy after done", busy_o, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 result held", result_o, held);
        chk({tag, " no extra slot"}, slot_cnt, exp_slots);
        pending = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy_o, 1'b0);
        chk("R9 reset done", done_o, 1'b0);
        chk("R9 reset result", result_o, 3'b000);
        chk("R9 reset slot", slot_start_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // sweep of read values, preference and latency (R2, R3, R4, R5 in-limit)
        foreach (rsp_bit[k]) rsp_bit[k] = 1'b0;
        for (int d = 0; d < 3; d++) begin
            for (int v = 0; v < 8; v++) begin
                int dl;
                dl = (d == 0) ? 1 : (d == 1) ? 3 : T;
                run_step(v[0], v[1], v[2], dl, 3,
                    (v[0] & v[1]) ? "R2" : (v[0] ^ v[1]) ? "R4" : "R3");
            end
        end

        // R5: latency past the limit, and each slot silent in turn
        run_step(1'b0, 1'b0, 1'b1, T + 1, 3, "R5 late");
        for (int s = 0; s < 3; s++) begin
            run_step(1'b0, 1'b1, 1'b0, 2, s, "R5 silent");
        end

        // R7: start while busy is ignored
        rsp_bit[0] = 1'b1; rsp_bit[1] = 1'b0;
        rsp_delay = 3; silent_idx = 3; slot_cnt = 0;
        pulse_go(1'b0);
        @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        wait_done();
        chk("R7 result", result_o, 3'b101);
        repeat (12) @(negedge clk);
        chk("R7 slots", slot_cnt, 3);
        chk("R7 idle", busy_o, 1'b0);

        // R8: preference change mid-step has no effect
        rsp_bit[0] = 1'b0; rsp_bit[1] = 1'b0;
        slot_cnt = 0;
        pulse_go(1'b1);
        pref_dir_i = 1'b0;
        wait_done();
        chk("R8 result", result_o, 3'b100);
        chk("R8 wval", last_wval, 1'b1);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule